// File: doc/BRIEF.md
# Interrupt Wakeup Dispatcher with Timeouts

This block converts hardware interrupt requests into process wakeups on condition variables. Each request line has a pending bit in a pending word, and the top bit of that word masks dispatch. A disable counter sets and clears the mask: it rises on every disable-increment and falls only when the counter returns to zero. When the word is positive (mask clear, at least one request pending) and the sequencer is idle, the block takes every pending bit as one batch. It then walks the channels in ascending order. For each taken channel it reads a pointer from an external channel table, and a zero pointer drops that request. A non-zero pointer selects a condition-variable word. If that variable's queue field is empty, the block sets the variable's wakeup-waiting flag. Otherwise it asks an external queue engine to wake the head waiter.

Request line 4 is the timer line. Every third timer dispatch advances a tick counter and then scans a table of per-process timeout words. Each entry equal to the new time and not zero causes a timeout wakeup and is then cleared. Timeout words are loaded by a wait command, which stores the current time plus the tick count. A tick count of zero disables the timeout, and a sum of zero is stored as 1. After a dispatch that issued at least one wakeup, a one-cycle reschedule pulse tells the scheduler to look at the ready queue again.

Top module: `irq_wake_dispatch`

## Requirements
- R1: A `dis_inc` pulse, without `dis_dec` in the same cycle, adds one to the disable counter (saturating) and sets `masked` in the next cycle.
- R2: A `dis_dec` pulse, without `dis_inc` in the same cycle, subtracts one from the disable counter. `masked` clears only when the counter reaches zero. A decrement at zero is ignored.
- R3: A dispatch (`busy` high) starts only when `masked` is low, a request is pending, the sequencer is idle and no grace period is open. All bits pending at the start are taken and cleared. Requests that arrive during a dispatch are held for the next dispatch.
- R4: A decrement that clears `masked` opens a grace period. No dispatch starts until a later `insn_done` pulse closes it.
- R5: Taken channels are handled from channel 0 upward, with `tbl_idx` equal to the channel number. A table pointer of zero discards the request and produces no variable write and no wakeup.
- R6: When the addressed variable's queue field (`cv_rdata[14:0]`) is zero, the block asserts `cv_we` for one cycle. `cv_wdata` then has bit 15 set and the queue field unchanged.
- R7: When the queue field is non-zero, the block raises `wake_req` with `wake_by_tmo`=0 and `wake_cv` equal to the pointer. It holds these signals steady until `wake_ack`, then continues with the next channel.
- R8: The timer line is channel 4. The tick counter `now_ticks` advances by one on the 3rd, 6th, 9th, … timer dispatch after reset, and on no others.
- R9: Right after an advance, and before any channel work, timeout entries are scanned from process 0 upward. Each entry that is non-zero and equal to the new time raises `wake_req` with `wake_by_tmo`=1 and `wake_pid` set. The entry is cleared on `wake_ack`.
- R10: A `wait_set` pulse stores `now_ticks + wait_ticks` (modulo the tick width) for `wait_pid`. A tick count of zero stores 0, which never times out. A sum of zero is stored as 1.
- R11: `resched` pulses for exactly one cycle at the end of a dispatch in which at least one wakeup was acknowledged. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_CH | Interrupt request pulses, ORed into the pending word |
| dis_inc | input | 1 | Increment the disable counter |
| dis_dec | input | 1 | Decrement the disable counter |
| insn_done | input | 1 | One instruction completed (closes the grace period) |
| wait_set | input | 1 | Load a timeout word |
| wait_pid | input | PIDW | Process whose timeout is loaded |
| wait_ticks | input | TW | Relative tick count of the wait |
| tbl_idx | output | CHW | Channel table index |
| tbl_ptr | input | PW | Condition-variable pointer read from the table |
| cv_addr | output | PW | Address of the condition-variable word |
| cv_rdata | input | PW+1 | Variable word: bit 15 wakeup-waiting, bits 14:0 queue |
| cv_we | output | 1 | Write strobe for the variable word |
| cv_wdata | output | PW+1 | Variable word to write |
| wake_req | output | 1 | Wake request to the queue engine |
| wake_by_tmo | output | 1 | 1 = timeout wakeup of `wake_pid`, 0 = head of `wake_cv` |
| wake_cv | output | PW | Variable whose head waiter is woken |
| wake_pid | output | PIDW | Process woken by timeout |
| wake_ack | input | 1 | Queue engine finished the wakeup |
| resched | output | 1 | Reschedule pulse |
| now_ticks | output | TW | Current tick count |
| masked | output | 1 | Dispatch masked (disable counter non-zero) |
| busy | output | 1 | Dispatch in progress |

## Verification
The hardest state to reach from the ports is a timeout whose stored value wrapped to zero and was replaced by 1. It fires only after the tick counter wraps, which takes three timer dispatches per step. The bench therefore narrows the tick width, then runs over a hundred random dispatch rounds with the timer line usually set. It places one wrapping wait and one zero-tick wait on reserved processes and counts their wakeups at the end. A directed round also injects a request while a dispatch is in progress, which checks that the late request is carried into a second dispatch.

// File: rtl/idw_pkg.sv
package idw_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_SCAN  = 3'd1,
    SQ_TWAKE = 3'd2,
    SQ_CHAN  = 3'd3,
    SQ_CWAKE = 3'd4,
    SQ_DONE  = 3'd5
  } seq_state_e;

  localparam int unsigned TICK_DIVIDE = 3;
endpackage

// File: rtl/idw_mask_ctl.sv
module idw_mask_ctl #(
  parameter int unsigned N_CH  = 15,
  parameter int unsigned WDC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dis_inc,
  input  logic            dis_dec,
  input  logic            insn_done,
  input  logic [N_CH-1:0] irq_in,
  input  logic            take,
  output logic [N_CH-1:0] req_vec,
  output logic            masked,
  output logic            ready
);
  localparam logic [WDC_W-1:0] CNT_MAX = '1;
  localparam logic [WDC_W-1:0] CNT_ONE = WDC_W'(1);

  logic [WDC_W-1:0] cnt_q, cnt_d;
  logic [N_CH:0]    pend_q, pend_d;
  logic             grace_q, grace_d;
  logic             cnt_en, grace_en;
  logic             inc_only, dec_only, dec_to_zero;

  assign inc_only    = dis_inc & ~dis_dec;
  assign dec_only    = dis_dec & ~dis_inc;
  assign dec_to_zero = dec_only & (cnt_q == CNT_ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (inc_only && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end else if (dec_only && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end
  assign cnt_en = inc_only | dec_only;

  always_comb begin
    pend_d = pend_q;
    if (inc_only) begin
      pend_d[N_CH] = 1'b1;
    end else if (dec_to_zero) begin
      pend_d[N_CH] = 1'b0;
    end
    pend_d[N_CH-1:0] = (take ? '0 : pend_q[N_CH-1:0]) | irq_in;
  end

  always_comb begin
    grace_d = grace_q;
    if (dec_to_zero) begin
      grace_d = 1'b1;
    end else if (insn_done) begin
      grace_d = 1'b0;
    end
  end
  assign grace_en = dec_to_zero | insn_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace_q <= 1'b0;
    end else if (grace_en) begin
      grace_q <= grace_d;
    end
  end

  assign req_vec = pend_q[N_CH-1:0];
  assign masked  = pend_q[N_CH];
  assign ready   = ~pend_q[N_CH] & (|pend_q[N_CH-1:0]) & ~grace_q;

  // R1
  inc_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_only |=> masked);

  // R2
  unmask_needs_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(masked) |-> $past(dis_dec));

  // R4
  grace_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grace_q |-> !take);
endmodule

// File: rtl/idw_timebase.sv
module idw_timebase #(
  parameter int unsigned TW    = 16,
  parameter int unsigned NPROC = 8,
  parameter int unsigned PIDW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_evt,
  input  logic            wait_set,
  input  logic [PIDW-1:0] wait_pid,
  input  logic [TW-1:0]   wait_ticks,
  input  logic            clr_en,
  input  logic [PIDW-1:0] clr_pid,
  input  logic [PIDW-1:0] scan_pid,
  output logic [TW-1:0]   now,
  output logic            advance,
  output logic            hit
);
  import idw_pkg::*;

  localparam logic [1:0] DIV_LAST = 2'(TICK_DIVIDE - 1);

  logic [1:0]    div_q, div_d;
  logic [TW-1:0] now_q, now_d;
  logic [TW-1:0] sum, wait_val;
  logic [TW-1:0] tmo_q [NPROC];

  assign advance = tick_evt & (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    now_d = now_q;
    if (tick_evt) begin
      div_d = advance ? 2'd0 : (div_q + 2'd1);
    end
    if (advance) begin
      now_d = now_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 2'd0;
      now_q <= '0;
    end else if (tick_evt) begin
      div_q <= div_d;
      now_q <= now_d;
    end
  end

  assign sum = now_q + wait_ticks;
  always_comb begin
    if (wait_ticks == '0) begin
      wait_val = '0;
    end else if (sum == '0) begin
      wait_val = TW'(1);
    end else begin
      wait_val = sum;
    end
  end

  for (genvar gp = 0; gp < NPROC; gp++) begin : g_tmo
    logic          ld, clr, en;
    logic [TW-1:0] d;
    assign ld  = wait_set & (wait_pid == PIDW'(gp));
    assign clr = clr_en & (clr_pid == PIDW'(gp));
    assign en  = ld | clr;
    assign d   = ld ? wait_val : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmo_q[gp] <= '0;
      end else if (en) begin
        tmo_q[gp] <= d;
      end
    end
  end

  assign hit = (tmo_q[scan_pid] != '0) && (tmo_q[scan_pid] == now_q);
  assign now = now_q;

  // R8
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_q != 2'd3);

  // R8
  now_moves_on_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (now_q != $past(now_q)) |-> $past(tick_evt));
endmodule

// File: rtl/idw_sequencer.sv
module idw_sequencer #(
  parameter int unsigned N_CH     = 15,
  parameter int unsigned CHW      = 4,
  parameter int unsigned NPROC    = 8,
  parameter int unsigned PIDW     = 3,
  parameter int unsigned PW       = 15,
  parameter int unsigned TIMER_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ready,
  input  logic [N_CH-1:0] req_vec,
  input  logic            advance,
  input  logic            hit,
  input  logic [PW-1:0]   tbl_ptr,
  input  logic [PW:0]     cv_rdata,
  input  logic            wake_ack,
  output logic            take,
  output logic            tick_evt,
  output logic [PIDW-1:0] scan_pid,
  output logic            clr_en,
  output logic [CHW-1:0]  tbl_idx,
  output logic [PW-1:0]   cv_addr,
  output logic            cv_we,
  output logic [PW:0]     cv_wdata,
  output logic            wake_req,
  output logic            wake_by_tmo,
  output logic [PW-1:0]   wake_cv,
  output logic [PIDW-1:0] wake_pid,
  output logic            resched,
  output logic            busy
);
  import idw_pkg::*;

  localparam logic [CHW-1:0]  CH_LAST  = CHW'(N_CH - 1);
  localparam logic [PIDW-1:0] PID_LAST = PIDW'(NPROC - 1);

  seq_state_e      st_q, st_d;
  logic [N_CH-1:0] taken_q, taken_d;
  logic [CHW-1:0]  idx_q, idx_d;
  logic [PIDW-1:0] pid_q, pid_d;
  logic [PW-1:0]   cv_q, cv_d;
  logic            woke_q, woke_d;
  logic            ch_live, q_empty;

  assign ch_live = taken_q[idx_q] & (tbl_ptr != '0);
  assign q_empty = (cv_rdata[PW-1:0] == '0);

  always_comb begin
    st_d        = st_q;
    taken_d     = taken_q;
    idx_d       = idx_q;
    pid_d       = pid_q;
    cv_d        = cv_q;
    woke_d      = woke_q;
    take        = 1'b0;
    tick_evt    = 1'b0;
    clr_en      = 1'b0;
    cv_we       = 1'b0;
    wake_req    = 1'b0;
    wake_by_tmo = 1'b0;
    resched     = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (ready) begin
          take     = 1'b1;
          tick_evt = req_vec[TIMER_CH];
          taken_d  = req_vec;
          woke_d   = 1'b0;
          pid_d    = '0;
          idx_d    = '0;
          st_d     = advance ? SQ_SCAN : SQ_CHAN;
        end
      end
      SQ_SCAN: begin
        if (hit) begin
          st_d = SQ_TWAKE;
        end else if (pid_q == PID_LAST) begin
          st_d = SQ_CHAN;
        end else begin
          pid_d = pid_q + PIDW'(1);
        end
      end
      SQ_TWAKE: begin
        wake_req    = 1'b1;
        wake_by_tmo = 1'b1;
        if (wake_ack) begin
          clr_en = 1'b1;
          woke_d = 1'b1;
          if (pid_q == PID_LAST) begin
            st_d = SQ_CHAN;
          end else begin
            pid_d = pid_q + PIDW'(1);
            st_d  = SQ_SCAN;
          end
        end
      end
      SQ_CHAN: begin
        if (ch_live && q_empty) begin
          cv_we = 1'b1;
        end
        if (ch_live && !q_empty) begin
          cv_d = tbl_ptr;
          st_d = SQ_CWAKE;
        end else if (idx_q == CH_LAST) begin
          st_d = SQ_DONE;
        end else begin
          idx_d = idx_q + CHW'(1);
        end
      end
      SQ_CWAKE: begin
        wake_req = 1'b1;
        if (wake_ack) begin
          woke_d = 1'b1;
          if (idx_q == CH_LAST) begin
            st_d = SQ_DONE;
          end else begin
            idx_d = idx_q + CHW'(1);
            st_d  = SQ_CHAN;
          end
        end
      end
      SQ_DONE: begin
        resched = woke_q;
        st_d    = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      taken_q <= '0;
      idx_q   <= '0;
      pid_q   <= '0;
      cv_q    <= '0;
      woke_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      taken_q <= taken_d;
      idx_q   <= idx_d;
      pid_q   <= pid_d;
      cv_q    <= cv_d;
      woke_q  <= woke_d;
    end
  end

  assign scan_pid = pid_q;
  assign tbl_idx  = idx_q;
  assign cv_addr  = tbl_ptr;
  assign cv_wdata = {1'b1, cv_rdata[PW-1:0]};
  assign wake_cv  = cv_q;
  assign wake_pid = pid_q;
  assign busy     = (st_q != SQ_IDLE);

  // R7
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_ack) |=> (wake_req && $stable(wake_cv) &&
                                 $stable(wake_pid) && $stable(wake_by_tmo)));

  // R5
  no_null_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_we |-> (cv_addr != '0) && !wake_req);

  // R5
  no_null_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_by_tmo) |-> (wake_cv != '0));

  // R11
  resched_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resched |=> !resched);
endmodule

// File: rtl/irq_wake_dispatch.sv
module irq_wake_dispatch #(
  parameter int unsigned N_CH     = 15,
  parameter int unsigned PW       = 15,
  parameter int unsigned TW       = 16,
  parameter int unsigned NPROC    = 8,
  parameter int unsigned WDC_W    = 4,
  parameter int unsigned TIMER_CH = 4,
  localparam int unsigned CHW     = $clog2(N_CH),
  localparam int unsigned PIDW    = $clog2(NPROC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] irq_in,
  input  logic            dis_inc,
  input  logic            dis_dec,
  input  logic            insn_done,
  input  logic            wait_set,
  input  logic [PIDW-1:0] wait_pid,
  input  logic [TW-1:0]   wait_ticks,
  output logic [CHW-1:0]  tbl_idx,
  input  logic [PW-1:0]   tbl_ptr,
  output logic [PW-1:0]   cv_addr,
  input  logic [PW:0]     cv_rdata,
  output logic            cv_we,
  output logic [PW:0]     cv_wdata,
  output logic            wake_req,
  output logic            wake_by_tmo,
  output logic [PW-1:0]   wake_cv,
  output logic [PIDW-1:0] wake_pid,
  input  logic            wake_ack,
  output logic            resched,
  output logic [TW-1:0]   now_ticks,
  output logic            masked,
  output logic            busy
);
  logic            rst_meta, rst_s;
  logic [N_CH-1:0] req_vec;
  logic            ready, take, tick_evt, advance, hit, clr_en;
  logic [PIDW-1:0] scan_pid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  idw_mask_ctl #(.N_CH(N_CH), .WDC_W(WDC_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_s),
    .dis_inc   (dis_inc),
    .dis_dec   (dis_dec),
    .insn_done (insn_done),
    .irq_in    (irq_in),
    .take      (take),
    .req_vec   (req_vec),
    .masked    (masked),
    .ready     (ready)
  );

  idw_timebase #(.TW(TW), .NPROC(NPROC), .PIDW(PIDW)) u_time (
    .clk        (clk),
    .rst_n      (rst_s),
    .tick_evt   (tick_evt),
    .wait_set   (wait_set),
    .wait_pid   (wait_pid),
    .wait_ticks (wait_ticks),
    .clr_en     (clr_en),
    .clr_pid    (wake_pid),
    .scan_pid   (scan_pid),
    .now        (now_ticks),
    .advance    (advance),
    .hit        (hit)
  );

  idw_sequencer #(
    .N_CH(N_CH), .CHW(CHW), .NPROC(NPROC), .PIDW(PIDW), .PW(PW), .TIMER_CH(TIMER_CH)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_s),
    .ready       (ready),
    .req_vec     (req_vec),
    .advance     (advance),
    .hit         (hit),
    .tbl_ptr     (tbl_ptr),
    .cv_rdata    (cv_rdata),
    .wake_ack    (wake_ack),
    .take        (take),
    .tick_evt    (tick_evt),
    .scan_pid    (scan_pid),
    .clr_en      (clr_en),
    .tbl_idx     (tbl_idx),
    .cv_addr     (cv_addr),
    .cv_we       (cv_we),
    .cv_wdata    (cv_wdata),
    .wake_req    (wake_req),
    .wake_by_tmo (wake_by_tmo),
    .wake_cv     (wake_cv),
    .wake_pid    (wake_pid),
    .resched     (resched),
    .busy        (busy)
  );
endmodule

// File: tb/irq_wake_dispatch_tb.sv
`timescale 1ns/1ps
module irq_wake_dispatch_tb;
  localparam int TWB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] irq_in;
  logic        dis_inc, dis_dec, insn_done, wait_set;
  logic [2:0]  wait_pid;
  logic [TWB-1:0] wait_ticks;
  logic [3:0]  tbl_idx;
  logic [14:0] tbl_ptr;
  logic [14:0] cv_addr;
  logic [15:0] cv_rdata;
  logic        cv_we;
  logic [15:0] cv_wdata;
  logic        wake_req, wake_by_tmo, wake_ack;
  logic [14:0] wake_cv;
  logic [2:0]  wake_pid;
  logic        resched, masked, busy;
  logic [TWB-1:0] now_ticks;

  irq_wake_dispatch #(.TW(TWB)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .dis_inc(dis_inc), .dis_dec(dis_dec),
    .insn_done(insn_done), .wait_set(wait_set), .wait_pid(wait_pid),
    .wait_ticks(wait_ticks), .tbl_idx(tbl_idx), .tbl_ptr(tbl_ptr), .cv_addr(cv_addr),
    .cv_rdata(cv_rdata), .cv_we(cv_we), .cv_wdata(cv_wdata), .wake_req(wake_req),
    .wake_by_tmo(wake_by_tmo), .wake_cv(wake_cv), .wake_pid(wake_pid),
    .wake_ack(wake_ack), .resched(resched), .now_ticks(now_ticks),
    .masked(masked), .busy(busy)
  );

  always #2 clk = ~clk;

  // bench memories (table and variable words)
  logic [14:0] tblm [16];
  logic [15:0] cvmem [16];
  assign tbl_ptr  = tblm[tbl_idx];
  assign cv_rdata = cvmem[cv_addr[3:0]];

  // expected model
  logic [15:0] ecv [16];
  int etmo [8];
  int enow, ediv;

  int n_chk = 0, n_err = 0;
  int act_log [64];
  int exp_log [64];
  int act_n, exp_n, act_res, exp_res;
  int pid7_wakes = 0, pid6_wakes = 0;
  bit ack_armed = 0;
  int ack_wait = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // variable-word write monitor (R6)
  always @(negedge clk) begin
    if (rst_n && cv_we) begin
      chk(cv_wdata == {1'b1, cvmem[cv_addr[3:0]][14:0]}, "R6 wdata",
          int'(cv_wdata), int'({1'b1, cvmem[cv_addr[3:0]][14:0]}));
      if (act_n < 64) act_log[act_n] = 1000 + int'(cv_addr);
      act_n++;
      cvmem[cv_addr[3:0]] = cv_wdata;
    end
    if (rst_n && resched) act_res++;
  end

  // queue engine model: acknowledges after a random delay
  always @(negedge clk) begin
    if (wake_ack) begin
      wake_ack = 1'b0;
    end else if (wake_req && !ack_armed) begin
      if (wake_by_tmo) begin
        if (act_n < 64) act_log[act_n] = 3000 + int'(wake_pid);
        if (wake_pid == 3'd7) pid7_wakes++;
        if (wake_pid == 3'd6) pid6_wakes++;
      end else begin
        if (act_n < 64) act_log[act_n] = 2000 + int'(wake_cv);
        cvmem[wake_cv[3:0]][14:0] = cvmem[wake_cv[3:0]][14:0] - 15'd1;
      end
      act_n++;
      ack_armed = 1'b1;
      ack_wait  = $urandom_range(0, 2);
    end else if (ack_armed) begin
      if (ack_wait == 0) begin
        wake_ack  = 1'b1;
        ack_armed = 1'b0;
      end else begin
        ack_wait--;
      end
    end
  end

  task automatic push(input int k, input int v);
    if (exp_n < 64) exp_log[exp_n] = k * 1000 + v;
    exp_n++;
  endtask

  task automatic build_expected(input logic [14:0] m);
    int wakes = 0;
    if (m[4]) begin
      ediv++;
      if (ediv == 3) begin
        ediv = 0;
        enow = (enow + 1) % 16;
        for (int p = 0; p < 8; p++) begin
          if (etmo[p] != 0 && etmo[p] == enow) begin
            push(3, p);
            etmo[p] = 0;
            wakes++;
          end
        end
      end
    end
    for (int c = 0; c < 15; c++) begin
      if (m[c] && tblm[c] != 0) begin
        int a = int'(tblm[c]);
        if (ecv[a][14:0] == 0) begin
          push(1, a);
          ecv[a][15] = 1'b1;
        end else begin
          push(2, a);
          ecv[a][14:0] = ecv[a][14:0] - 15'd1;
          wakes++;
        end
      end
    end
    if (wakes > 0) exp_res++;
  endtask

  task automatic do_inc();
    @(negedge clk); dis_inc = 1'b1; @(negedge clk); dis_inc = 1'b0;
  endtask
  task automatic do_dec();
    @(negedge clk); dis_dec = 1'b1; @(negedge clk); dis_dec = 1'b0;
  endtask
  task automatic do_insn();
    @(negedge clk); insn_done = 1'b1; @(negedge clk); insn_done = 1'b0;
  endtask
  task automatic do_irq(input logic [14:0] m);
    @(negedge clk); irq_in = m; @(negedge clk); irq_in = '0;
  endtask
  task automatic do_wait(input int pid, input int t);
    int s;
    @(negedge clk);
    wait_set = 1'b1; wait_pid = 3'(pid); wait_ticks = TWB'(t);
    @(negedge clk);
    wait_set = 1'b0;
    s = (enow + t) % 16;
    etmo[pid] = (t == 0) ? 0 : ((s == 0) ? 1 : s);
  endtask

  task automatic randomize_mem();
    for (int c = 0; c < 16; c++) begin
      tblm[c] = ($urandom_range(0, 3) == 0) ? 15'd0 : 15'($urandom_range(1, 15));
      cvmem[c] = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom_range(1, 3));
      ecv[c] = cvmem[c];
    end
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 3000 && q < 4; i++) begin
      @(negedge clk);
      if (!busy && !wake_req && !ack_armed) q++; else q = 0;
    end
  endtask

  task automatic compare_round();
    chk(act_n == exp_n, "R5 event count", act_n, exp_n);
    for (int i = 0; i < act_n && i < exp_n && i < 64; i++) begin
      case (exp_log[i] / 1000)
        1: chk(act_log[i] == exp_log[i], "R6 write order", act_log[i], exp_log[i]);
        2: chk(act_log[i] == exp_log[i], "R7 wake order", act_log[i], exp_log[i]);
        default: chk(act_log[i] == exp_log[i], "R9 timeout order", act_log[i], exp_log[i]);
      endcase
    end
    chk(act_res == exp_res, "R11 resched count", act_res, exp_res);
    chk(int'(now_ticks) == enow, "R8 tick count", int'(now_ticks), enow);
  endtask

  task automatic run_round(input logic [14:0] m, input logic [14:0] extra);
    bit seen = 0;
    act_n = 0; exp_n = 0; act_res = 0; exp_res = 0;
    do_inc();
    chk(masked == 1'b1, "R1 mask after inc", int'(masked), 1);
    do_irq(m);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R3 no dispatch while masked", int'(busy), 0);
    do_dec();
    chk(masked == 1'b0, "R2 unmask at zero", int'(masked), 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R4 grace holds", int'(busy), 0);
    build_expected(m);
    do_insn();
    for (int i = 0; i < 10 && !seen; i++) begin
      if (busy) seen = 1; else @(negedge clk);
    end
    chk(seen, "R3 dispatch starts", int'(seen), 1);
    if (extra != '0) begin
      do_irq(extra);
      build_expected(extra);
    end
    wait_quiet();
    compare_round();
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [14:0] m;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; irq_in = '0; dis_inc = 0; dis_dec = 0; insn_done = 0;
    wait_set = 0; wait_pid = '0; wait_ticks = '0; wake_ack = 0;
    act_n = 0; exp_n = 0; act_res = 0; exp_res = 0;
    enow = 0; ediv = 0;
    for (int p = 0; p < 8; p++) etmo[p] = 0;
    for (int c = 0; c < 16; c++) begin tblm[c] = '0; cvmem[c] = '0; ecv[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(masked == 0, "R1 reset masked", int'(masked), 0);
    chk(busy == 0, "R3 reset busy", int'(busy), 0);
    chk(wake_req == 0 && cv_we == 0 && resched == 0, "R11 reset outputs",
        int'({wake_req, cv_we, resched}), 0);
    chk(now_ticks == 0, "R8 reset ticks", int'(now_ticks), 0);

    // R2 nesting and decrement at zero
    do_inc(); do_inc(); do_dec();
    chk(masked == 1, "R2 nested still masked", int'(masked), 1);
    do_dec();
    chk(masked == 0, "R2 cleared at zero", int'(masked), 0);
    do_dec();
    chk(masked == 0, "R2 dec at zero ignored", int'(masked), 0);
    do_inc();
    chk(masked == 1, "R1 counter not wrapped", int'(masked), 1);
    do_dec();
    chk(masked == 0, "R2 single dec clears", int'(masked), 0);
    do_insn();

    // R10 zero-tick wait never fires
    do_wait(6, 0);

    // R5/R11 zero pointer: no events, no reschedule
    randomize_mem();
    tblm[0] = '0;
    run_round(15'h0001, '0);

    // R3 late request carried to a second dispatch
    randomize_mem();
    tblm[2] = 15'd5; cvmem[5] = 16'd0; ecv[5] = 16'd0;
    tblm[9] = 15'd6; cvmem[6] = 16'd2; ecv[6] = 16'd2;
    run_round(15'h0004, 15'h0200);

    for (int r = 0; r < 130; r++) begin
      randomize_mem();
      if (r >= 10 && enow != 0 && etmo[7] == 0 && pid7_wakes == 0 && r < 12) begin
        do_wait(7, 16 - enow);  // sum wraps to zero, stored as 1 (R10)
      end
      if ($urandom_range(0, 3) == 0) do_wait($urandom_range(0, 5), $urandom_range(0, 15));
      m = 15'($urandom);
      m[4] = ($urandom_range(0, 3) != 0);
      if (m == '0) m = 15'h0001;
      run_round(m, '0);
    end

    chk(pid7_wakes == 1, "R10 wrapped wait fires once", pid7_wakes, 1);
    chk(pid6_wakes == 0, "R10 zero ticks never fires", pid6_wakes, 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule